// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs the external memory bus of a small processor core. A request from the core side becomes one bus cycle that lasts exactly one machine cycle of twelve clocks. The block handles three request kinds: a code fetch, a data access with a full 16-bit address, and a paged data access with an 8-bit address. One 8-bit low port carries the low address byte and then the data byte. A second 8-bit high port carries the upper address byte. The block drives an address latch enable and active-low read, write and program-store strobes. It also decides whether each code fetch is served from internal code memory or from the external bus.

The block holds the two port latch registers that the core writes through a simple register write strobe. When the bus is idle, each port shows the contents of its latch register. A 16-bit access or an external fetch puts the upper address byte on the high port and leaves the high register unchanged. A paged access leaves the high register on the high port, so that register acts as the page number. Every external access overwrites the low register with all ones. After an external cycle that is not directly followed by another one, the high port shows its register contents again.

Top module: `xbus_ctrl`

## Requirements
- R1: The block accepts a request only in the last phase (phase 11) of a machine cycle. `req_ack` is high in that phase exactly when `req_valid` is high and `req_kind` is 0, 1 or 2. The bus cycle fills the twelve phases that follow. Phases count 0..11 from the first clock after reset. Kind code 3 is never accepted.
- R2: In an external cycle, `ale` is high in phases 0-2. The low port drives `req_addr[7:0]` with `lo_oe`=1 in phases 0-3, so the address is valid when `ale` falls.
- R3: In an external cycle of kind 1 (16-bit data) or kind 0 (fetch), `hi_out` shows `req_addr[15:8]` in all twelve phases, and `hi_reg` does not change. In the phase after a cycle that is not followed by another one, `hi_out` shows `hi_reg` again.
- R4: In a cycle of kind 2 (paged data), `hi_out` shows `hi_reg` in all twelve phases.
- R5: In a data write (`req_write`=1), the low port drives `req_wdata` with `lo_oe`=1 in phases 4-11. `wr_n` is low in phases 5-10 only.
- R6: In a data read, `lo_oe` is 0 in phases 4-11 and `rd_n` is low in phases 5-10. `lo_in` is sampled at the clock edge that ends phase 10. `rsp_valid` is high for phase 11 only, with `rsp_data` holding the sampled byte.
- R7: Accepting any external cycle (data, or fetch routed externally) sets `lo_reg` to 0xFF. An internal fetch leaves `lo_reg` unchanged.
- R8: A fetch (kind 0) goes external when `ext_access_n`=0 or `req_addr` exceeds a limit set by `size_sel`: 0 gives 0x1FFF, 1 gives 0x3FFF, 2 and 3 give 0x7FFF. An external fetch drives `psen_n` low in phases 5-10, releases the low port in phases 4-11 and returns the byte as in R6. An internal fetch raises `fetch_int` for the twelve phases and produces no strobe, no bus activity and no `rsp_valid`.
- R9: When no cycle is active, `ale`=0, all strobes are high, `lo_oe`=1, `lo_out`=`lo_reg` and `hi_out`=`hi_reg`.
- R10: At most one of `ale`, `rd_n` low, `wr_n` low and `psen_n` low is active in any clock.
- R11: Reset sets both latch registers to 0xFF. `sfr_lo_wr` or `sfr_hi_wr` loads `sfr_wdata` into `lo_reg` or `hi_reg` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_kind | input | 2 | 0 fetch, 1 16-bit data, 2 paged data, 3 invalid |
| req_write | input | 1 | Data access is a write |
| req_addr | input | 16 | Address or program counter |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | Request taken at this edge |
| rsp_valid | output | 1 | Read or fetch byte available |
| rsp_data | output | 8 | Returned byte |
| size_sel | input | 2 | Internal code size selector |
| ext_access_n | input | 1 | Low forces all fetches external |
| sfr_lo_wr | input | 1 | Write low port latch register |
| sfr_hi_wr | input | 1 | Write high port latch register |
| sfr_wdata | input | 8 | Latch register write data |
| lo_reg | output | 8 | Low port latch register |
| hi_reg | output | 8 | High port latch register |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input value |
| hi_out | output | 8 | High port output value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | Program store enable, active low |
| fetch_int | output | 1 | Current cycle is an internal fetch |

## Verification
The high-register assertion assumes the core does not write the high latch register in the same clock in which a request is accepted. The response assertion assumes `lo_in` holds steady while a read strobe is low. The bench writes latch registers only while the bus is idle. It drives `lo_in` from the middle of phase 4 until after the capture edge, and it holds `req_valid` and the request fields through the accepting edge, changing them only at falling clock edges.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        XK_FETCH = 2'b00,
        XK_WIDE  = 2'b01,
        XK_PAGED = 2'b10,
        XK_NONE  = 2'b11
    } xkind_e;
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          last
);
    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        last = (ph_q == PW'(PHASES - 1));
        ph_d = last ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign phase = ph_q;
endmodule

// File: rtl/xbus_fetch_route.sv
module xbus_fetch_route
    import xbus_pkg::*;
#(
    parameter int AW       = 16,
    parameter int LIM_LOG2 = 13
) (
    input  logic [AW-1:0] addr,
    input  xkind_e        kind,
    input  logic [1:0]    size_sel,
    input  logic          ext_access_n,
    output logic          go_ext
);
    int unsigned   sh;
    logic [AW-1:0] limit;

    always_comb begin
        sh     = LIM_LOG2 + ((size_sel > 2'd2) ? 2 : int'(size_sel));
        limit  = (AW'(1) << sh) - AW'(1);
        go_ext = (kind != XK_FETCH) || !ext_access_n || (addr > limit);
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int PHASES    = 12,
    parameter int ALE_LAST  = 2,
    parameter int ADDR_LAST = 3,
    parameter int STB_FIRST = 5,
    parameter int STB_LAST  = 10,
    localparam int PW = $clog2(PHASES)
) (
    input  logic [PW-1:0] phase,
    input  logic          busy,
    input  xkind_e        kind,
    input  logic          write,
    output logic          ale,
    output logic          addr_ph,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic          ps_stb,
    output logic          cap
);
    logic in_stb, is_data;

    always_comb begin
        is_data = (kind != XK_FETCH);
        in_stb  = (phase >= PW'(STB_FIRST)) && (phase <= PW'(STB_LAST));
        ale     = busy && (phase <= PW'(ALE_LAST));
        addr_ph = busy && (phase <= PW'(ADDR_LAST));
        rd_stb  = busy && in_stb && is_data && !write;
        wr_stb  = busy && in_stb && is_data && write;
        ps_stb  = busy && in_stb && !is_data;
        cap     = busy && (phase == PW'(STB_LAST)) && !(is_data && write);
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int PHASES    = 12,
    parameter int LIM_LOG2  = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    input  logic [1:0]    size_sel,
    input  logic          ext_access_n,
    input  logic          sfr_lo_wr,
    input  logic          sfr_hi_wr,
    input  logic [DW-1:0] sfr_wdata,
    output logic [DW-1:0] lo_reg,
    output logic [DW-1:0] hi_reg,
    output logic [DW-1:0] lo_out,
    output logic          lo_oe,
    input  logic [DW-1:0] lo_in,
    output logic [DW-1:0] hi_out,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          psen_n,
    output logic          fetch_int
);
    localparam int PW = $clog2(PHASES);

    typedef struct packed {
        logic          active;
        logic          ext;
        xkind_e        kind;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] lo_reg;
        logic [DW-1:0] hi_reg;
        logic [DW-1:0] rdata;
        logic          rsp_v;
    } st_t;

    st_t           s_d, s_q;
    logic [PW-1:0] phase;
    logic          last, accept, route_ext, busy;
    logic          addr_ph, rd_stb, wr_stb, ps_stb, cap;
    xkind_e        in_kind;

    assign in_kind = xkind_e'(req_kind);
    assign busy    = s_q.active && s_q.ext;

    xbus_phase_ctr #(.PHASES(PHASES)) i_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase), .last(last)
    );

    xbus_fetch_route #(.AW(AW), .LIM_LOG2(LIM_LOG2)) i_route (
        .addr(req_addr), .kind(in_kind), .size_sel(size_sel),
        .ext_access_n(ext_access_n), .go_ext(route_ext)
    );

    xbus_strobe_gen #(.PHASES(PHASES)) i_strobe (
        .phase(phase), .busy(busy), .kind(s_q.kind), .write(s_q.write),
        .ale(ale), .addr_ph(addr_ph), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .ps_stb(ps_stb), .cap(cap)
    );

    always_comb begin
        accept = last && req_valid && (in_kind != XK_NONE);
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        if (sfr_lo_wr) s_d.lo_reg = sfr_wdata;
        if (sfr_hi_wr) s_d.hi_reg = sfr_wdata;
        if (cap) begin
            s_d.rdata = lo_in;
            s_d.rsp_v = 1'b1;
        end
        if (last) begin
            s_d.active = accept;
            if (accept) begin
                s_d.ext   = route_ext;
                s_d.kind  = in_kind;
                s_d.write = req_write && (in_kind != XK_FETCH);
                s_d.addr  = req_addr;
                s_d.wdata = req_wdata;
                if (route_ext) s_d.lo_reg = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.kind   <= XK_FETCH;
            s_q.lo_reg <= '1;
            s_q.hi_reg <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        req_ack   = accept;
        rsp_valid = s_q.rsp_v;
        rsp_data  = s_q.rdata;
        lo_reg    = s_q.lo_reg;
        hi_reg    = s_q.hi_reg;
        rd_n      = !rd_stb;
        wr_n      = !wr_stb;
        psen_n    = !ps_stb;
        fetch_int = s_q.active && !s_q.ext;
        if (busy) begin
            lo_oe  = addr_ph || s_q.write;
            lo_out = addr_ph ? s_q.addr[DW-1:0] : s_q.wdata;
            hi_out = (s_q.kind == XK_PAGED) ? s_q.hi_reg : s_q.addr[AW-1 -: DW];
        end else begin
            lo_oe  = 1'b1;
            lo_out = s_q.lo_reg;
            hi_out = s_q.hi_reg;
        end
    end
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ack,
    input logic       rsp_valid,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       psen_n,
    input logic       lo_oe,
    input logic [7:0] lo_out,
    input logic [7:0] lo_reg,
    input logic [7:0] hi_reg,
    input logic       sfr_hi_wr,
    input logic       fetch_int,
    input logic       accept,
    input logic       route_ext
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ale, !rd_n, !wr_n, !psen_n}));

    assert_ale_after_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(req_ack));

    assert_addr_at_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (lo_oe && $stable(lo_out)));

    assert_wr_data_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (lo_oe && $stable(lo_out)));

    assert_wr_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> lo_oe);

    assert_rd_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !psen_n) |-> !lo_oe);

    assert_rsp_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!rd_n || !psen_n));

    assert_lo_filled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && route_ext) |=> (lo_reg == 8'hFF));

    assert_hi_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sfr_hi_wr) |=> $stable(hi_reg));

    assert_int_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_int |-> (!ale && rd_n && wr_n && psen_n));
endmodule

bind xbus_ctrl xbus_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .rsp_valid(rsp_valid),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n), .lo_oe(lo_oe),
    .lo_out(lo_out), .lo_reg(lo_reg), .hi_reg(hi_reg), .sfr_hi_wr(sfr_hi_wr),
    .fetch_int(fetch_int), .accept(accept), .route_ext(route_ext)
);

// File: tb/test_xbus_ctrl.sv
`timescale 1ns/1ps
module test_xbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_kind = 2'd0, size_sel = 2'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, sfr_wdata = '0, lo_in = '0;
    logic        ext_access_n = 1'b1, sfr_lo_wr = 1'b0, sfr_hi_wr = 1'b0;
    logic        req_ack, rsp_valid, lo_oe, ale, rd_n, wr_n, psen_n, fetch_int;
    logic [7:0]  rsp_data, lo_reg, hi_reg, lo_out, hi_out;

    int nchk = 0, nerr = 0, bph = 0;
    logic [7:0] lo_m = 8'hFF, hi_m = 8'hFF;
    bit done = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bph <= 0;
        else        bph <= (bph == 11) ? 0 : bph + 1;
    end

    xbus_ctrl i_xbus_ctrl (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " R9 ale"}, 16'(ale), 16'd0);
        chk({tag, " R9 strobes"}, 16'({rd_n, wr_n, psen_n}), 16'h7);
        chk({tag, " R9 lo_oe"}, 16'(lo_oe), 16'd1);
        chk({tag, " R9 lo_out"}, 16'(lo_out), 16'(lo_m));
        chk({tag, " R3 R9 hi_out"}, 16'(hi_out), 16'(hi_m));
        chk({tag, " R11 regs"}, {hi_reg, lo_reg}, {hi_m, lo_m});
    endtask

    task automatic sfr_write(input bit hi, input logic [7:0] v);
        @(negedge clk);
        sfr_wdata = v; sfr_hi_wr = hi; sfr_lo_wr = !hi;
        @(negedge clk);
        sfr_hi_wr = 0; sfr_lo_wr = 0;
        if (hi) hi_m = v; else lo_m = v;
    endtask

    function automatic bit want_ext(input logic [15:0] a, input logic [1:0] sz, input logic en);
        logic [15:0] lim;
        lim = (sz == 2'd0) ? 16'h1FFF : (sz == 2'd1) ? 16'h3FFF : 16'h7FFF;
        return !en || (a > lim);
    endfunction

    // One bus cycle; returns at the middle of its phase 11.
    task automatic run_cycle(input string tag, input logic [1:0] kind, input logic wr,
                             input logic [15:0] addr, input logic [7:0] wd,
                             input logic [7:0] rin, input bit ext);
        bit rd_like, wr_like;
        while (bph != 11) @(negedge clk);
        req_valid = 1; req_kind = kind; req_write = wr; req_addr = addr; req_wdata = wd;
        #1 chk({tag, " R1 ack"}, 16'(req_ack), 16'd1);
        @(negedge clk);
        req_valid = 0;
        if (ext) lo_m = 8'hFF;
        wr_like = ext && kind != 2'd0 && wr;
        rd_like = ext && !wr_like;
        for (int p = 0; p < 12; p++) begin
            if (p == 4) lo_in = rin;
            if (ext) begin
                chk($sformatf("%s R2 ale p%0d", tag, p), 16'(ale), 16'(p <= 2));
                chk($sformatf("%s R2 R5 R6 lo_oe p%0d", tag, p), 16'(lo_oe), 16'(p <= 3 || wr_like));
                if (p <= 3)
                    chk($sformatf("%s R2 addr p%0d", tag, p), 16'(lo_out), 16'(addr[7:0]));
                else if (wr_like)
                    chk($sformatf("%s R5 wdata p%0d", tag, p), 16'(lo_out), 16'(wd));
                chk($sformatf("%s R5 wr_n p%0d", tag, p), 16'(wr_n),
                    16'(!(wr_like && p >= 5 && p <= 10)));
                chk($sformatf("%s R6 rd_n p%0d", tag, p), 16'(rd_n),
                    16'(!(rd_like && kind != 2'd0 && p >= 5 && p <= 10)));
                chk($sformatf("%s R8 psen_n p%0d", tag, p), 16'(psen_n),
                    16'(!(kind == 2'd0 && p >= 5 && p <= 10)));
                chk($sformatf("%s R3 R4 hi_out p%0d", tag, p), 16'(hi_out),
                    16'((kind == 2'd2) ? hi_m : addr[15:8]));
                chk($sformatf("%s R8 fetch_int p%0d", tag, p), 16'(fetch_int), 16'd0);
            end else begin
                chk($sformatf("%s R8 int fetch_int p%0d", tag, p), 16'(fetch_int), 16'd1);
                chk($sformatf("%s R8 int bus p%0d", tag, p),
                    16'({ale, rd_n, wr_n, psen_n, lo_oe}), 16'b01111);
                chk($sformatf("%s R8 int ports p%0d", tag, p), {hi_out, lo_out}, {hi_m, lo_m});
            end
            chk($sformatf("%s R6 rsp_valid p%0d", tag, p), 16'(rsp_valid),
                16'(rd_like && p == 11));
            if (p == 11 && rd_like)
                chk({tag, " R6 rsp_data"}, 16'(rsp_data), 16'(rin));
            chk($sformatf("%s R3 R7 regs p%0d", tag, p), {hi_reg, lo_reg}, {hi_m, lo_m});
            if (p < 11) @(negedge clk);
        end
        lo_in = 8'h00;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_idle("reset R11");
    endtask

    task automatic t_sfr;
        sfr_write(1, 8'h5A);
        sfr_write(0, 8'h3C);
        check_idle("sfr R11");
    endtask

    task automatic t_reject;
        while (bph != 5) @(negedge clk);
        req_valid = 1; req_kind = 2'd1; req_addr = 16'h1234;
        #1 chk("R1 no ack mid-cycle", 16'(req_ack), 16'd0);
        @(negedge clk);
        req_valid = 0;
        check_idle("R1 no start");
        while (bph != 11) @(negedge clk);
        req_valid = 1; req_kind = 2'd3;
        #1 chk("R1 kind3 no ack", 16'(req_ack), 16'd0);
        @(negedge clk);
        req_valid = 0; req_kind = 2'd0;
        check_idle("R1 kind3 idle");
    endtask

    task automatic t_wide_write;
        run_cycle("wide wr", 2'd1, 1'b1, 16'h12A7, 8'hC3, 8'h00, 1);
        @(negedge clk);
        check_idle("after wide R3 R7");
    endtask

    task automatic t_paged_read;
        sfr_write(1, 8'h66);
        run_cycle("paged rd", 2'd2, 1'b0, 16'hBE44, 8'h00, 8'h9E, 1);
        @(negedge clk);
        check_idle("after paged R4");
    endtask

    task automatic t_fetch_route;
        sfr_write(0, 8'h11);
        size_sel = 2'd0;
        chk("R8 model 1FFF", 16'(want_ext(16'h1FFF, 2'd0, 1'b1)), 16'd0);
        run_cycle("fetch int 1FFF", 2'd0, 1'b0, 16'h1FFF, 8'h00, 8'hAA, 0);
        @(negedge clk);
        check_idle("after int fetch R7");
        run_cycle("fetch ext 2000", 2'd0, 1'b0, 16'h2000, 8'h00, 8'h77, want_ext(16'h2000, 2'd0, 1'b1));
        size_sel = 2'd1;
        sfr_write(0, 8'h22);
        run_cycle("fetch int 3FFF", 2'd0, 1'b0, 16'h3FFF, 8'h00, 8'h01, want_ext(16'h3FFF, 2'd1, 1'b1));
        run_cycle("fetch ext 4000", 2'd0, 1'b0, 16'h4000, 8'h00, 8'h5C, want_ext(16'h4000, 2'd1, 1'b1));
        size_sel = 2'd2;
        sfr_write(0, 8'h33);
        run_cycle("fetch int 7FFF", 2'd0, 1'b0, 16'h7FFF, 8'h00, 8'h02, want_ext(16'h7FFF, 2'd2, 1'b1));
        size_sel = 2'd3;
        run_cycle("fetch ext 8000", 2'd0, 1'b0, 16'h8000, 8'h00, 8'hE1, want_ext(16'h8000, 2'd3, 1'b1));
        ext_access_n = 0;
        run_cycle("fetch forced 0000", 2'd0, 1'b0, 16'h0000, 8'h00, 8'h4B, want_ext(16'h0000, 2'd3, 1'b0));
        ext_access_n = 1;
        @(negedge clk);
        check_idle("after fetch R8");
    endtask

    task automatic t_back_to_back;
        sfr_write(1, 8'h0F);
        run_cycle("b2b first R1", 2'd1, 1'b0, 16'hA155, 8'h00, 8'hD2, 1);
        run_cycle("b2b second R3", 2'd1, 1'b0, 16'h7C09, 8'h00, 8'h3E, 1);
        run_cycle("b2b third paged", 2'd2, 1'b1, 16'h0081, 8'h5F, 8'h00, 1);
        @(negedge clk);
        check_idle("after b2b R3");
    endtask

    initial begin
        t_reset();
        t_sfr();
        t_reject();
        t_wide_write();
        t_paged_read();
        t_fetch_route();
        t_back_to_back();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule